// File: doc/BRIEF.md
# Bridge Overcurrent and Undervoltage Fault Supervisor

This block sits between a three-phase bridge controller and its six gate drivers. It watches a digitised overcurrent trip flag, an undervoltage flag for the logic supply and one undervoltage flag for each of the three high-side supplies. From these it produces three outputs: a global kill that forces every drive output off, one high-side kill per phase, and an active-low fault indication.

All flag inputs and the three low-side command inputs are asynchronous, so each one passes through a two-stage synchroniser before the block uses it. A trip has to stay high for a blanking window before it counts. This lets switching spikes pass without stopping the bridge. A qualified trip latches. The latch releases only when the controller holds all three active-low low-side commands at their inactive (high) level for a timed clear interval. Undervoltage conditions are not latched: they follow their synchronised flag. Reset leaves the block in the latched, all-off state, so the first start-up also needs a clear sequence.

The blanking window and the clear interval are parameters counted in system clock cycles. Together with the two synchroniser stages, they set the shutdown latency.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: After reset is released, the overcurrent latch is set. While it stays set, `gate_kill`=1, `hs_kill`=3'b111 and `fault_n`=0. The latch releases only through the clear sequence of R5.
- R2: Suppose `trip_in` is high for at least BLANK_CYC consecutive clock edges. The first edge that samples it high counts as edge 1. Then `gate_kill`=1, `hs_kill`=3'b111 and `fault_n`=0 hold from edge BLANK_CYC+2 on, and not before.
- R3: A `trip_in` pulse of at most BLANK_CYC-1 edges changes no output. A low gap of one cycle restarts the blanking window, so two such pulses separated by a gap do not add up.
- R4: A latched overcurrent fault persists after `trip_in` returns low, for as long as any bit of `lo_cmd_n` is low (low means low-side commanded on).
- R5: With the latch set, suppose `lo_cmd_n` becomes 3'b111 and the first edge sampling that value is edge 1. The latch then releases at edge CLEAR_CYC+2: `fault_n`=1 and `gate_kill`=0 from that edge on, assuming no undervoltage.
- R6: Any `lo_cmd_n` bit sampled low during the clear interval restarts the interval from zero.
- R7: `uv_logic_in`=1 drives `gate_kill`=1, `hs_kill`=3'b111 and `fault_n`=0 from the second edge after it is raised. All three release two edges after it falls, and the state is not latched.
- R8: `uv_hs_in[i]`=1 sets only `hs_kill[i]`, two edges after it is raised. It leaves `gate_kill`, the other `hs_kill` bits and `fault_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_in | input | 1 | Asynchronous overcurrent trip flag, active high |
| uv_logic_in | input | 1 | Asynchronous logic-supply undervoltage flag, active high |
| uv_hs_in | input | 3 | Asynchronous high-side supply undervoltage flags, one per phase |
| lo_cmd_n | input | 3 | Asynchronous low-side commands, active low, one per phase |
| gate_kill | output | 1 | Forces all six drive outputs off |
| hs_kill | output | 3 | Per-phase high-side disable |
| fault_n | output | 1 | Fault indication, active low |

## Verification
Most internal errors appear on `fault_n` and `gate_kill`, usually within one clock cycle. A blanking counter that counts wrongly moves the shutdown edge by one or more cycles, or lets a short pulse through. The bench therefore samples one cycle before and one cycle at the expected edge. A clear timer that counts wrongly, or that fails to restart, releases the latch early or late by at least one cycle. A cross-wired undervoltage path shows up in the wrong `hs_kill` bit, or in `fault_n` responding to a high-side flag, two edges after the flag changes.

// File: rtl/bfs_pkg.sv
// Shared constants for the bridge fault supervisor.
// Assumes a three-phase bridge; the phase count sizes every per-phase vector.
package bfs_pkg;
    localparam int unsigned NUM_PHASE = 3;
    typedef logic [NUM_PHASE-1:0] phase_vec_t;
endpackage

// File: rtl/bfs_sync.sv
// Two-stage synchroniser for a vector of asynchronous level inputs.
// Assumes each bit is an independent slow level; no bus coherency is given.
// RST_VAL sets the value both stages take in reset (the safe assumption).
module bfs_sync #(
    parameter int unsigned        WIDTH   = 1,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/bfs_trip_qual.sv
// Blanking filter for the synchronised trip flag.
// Asserts hit_o once the trip has been sampled high on BLANK_CYC consecutive
// edges, and holds it while the trip stays high; any low sample restarts.
module bfs_trip_qual #(
    parameter int unsigned BLANK_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_s_i,
    output logic hit_o
);
    localparam int unsigned CW   = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);
    localparam logic [CW-1:0] LAST = CW'(BLANK_CYC - 1);

    logic [CW-1:0] blank_cnt;

    // Count consecutive high samples, saturating at the last window cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !trip_s_i) begin
            blank_cnt <= '0;
        end else if (blank_cnt != LAST) begin
            blank_cnt <= blank_cnt + 1'b1;
        end
    end

    assign hit_o = trip_s_i && (blank_cnt == LAST);

    // R3
    blank_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_s_i |=> (blank_cnt == '0) && !hit_o);
endmodule

// File: rtl/bfs_clear_timer.sv
// Clear-interval timer for the overcurrent latch.
// Counts edges on which the latch is set and all low-side commands are
// inactive; done_o pulses on the CLEAR_CYC-th such consecutive edge.
module bfs_clear_timer #(
    parameter int unsigned CLEAR_CYC = 180,
    parameter int unsigned NPH       = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           latched_i,
    input  logic [NPH-1:0] lo_s_i,
    output logic           done_o
);
    localparam int unsigned CW   = (CLEAR_CYC < 2) ? 1 : $clog2(CLEAR_CYC);
    localparam logic [CW-1:0] LAST = CW'(CLEAR_CYC - 1);

    logic          all_idle;
    logic [CW-1:0] clr_cnt;

    assign all_idle = &lo_s_i;

    // Advance while the clear condition holds, restart on any break.
    always_ff @(posedge clk) begin
        if (!rst_n || !(latched_i && all_idle)) begin
            clr_cnt <= '0;
        end else if (clr_cnt != LAST) begin
            clr_cnt <= clr_cnt + 1'b1;
        end
    end

    assign done_o = latched_i && all_idle && (clr_cnt == LAST);

    // R6
    clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_i && !all_idle) |=> (clr_cnt == '0));
    // R5
    clear_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt <= LAST);
endmodule

// File: rtl/bridge_fault_supervisor.sv
// Fault supervisor for a three-phase bridge gate driver.
// Synchronises all flags, blanks the trip, latches overcurrent faults and
// releases them through a timed idle period on the low-side commands.
// Assumes undervoltage hysteresis is applied upstream of the flags.
module bridge_fault_supervisor
    import bfs_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 8,
    parameter int unsigned CLEAR_CYC = 180
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip_in,
    input  logic       uv_logic_in,
    input  logic [2:0] uv_hs_in,
    input  logic [2:0] lo_cmd_n,
    output logic       gate_kill,
    output logic [2:0] hs_kill,
    output logic       fault_n
);
    logic       trip_s;
    logic       uv_logic_s;
    phase_vec_t uv_hs_s;
    phase_vec_t lo_s;
    logic       trip_hit;
    logic       clr_done;
    logic       oc_latched;

    bfs_sync #(.WIDTH(1), .RST_VAL(1'b0)) trip_sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(trip_in), .sync_o(trip_s));

    bfs_sync #(.WIDTH(1 + NUM_PHASE), .RST_VAL('1)) uv_sync_i (
        .clk(clk), .rst_n(rst_n), .async_i({uv_logic_in, uv_hs_in}),
        .sync_o({uv_logic_s, uv_hs_s}));

    bfs_sync #(.WIDTH(NUM_PHASE), .RST_VAL('0)) lo_sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(lo_cmd_n), .sync_o(lo_s));

    bfs_trip_qual #(.BLANK_CYC(BLANK_CYC)) qual_i (
        .clk(clk), .rst_n(rst_n), .trip_s_i(trip_s), .hit_o(trip_hit));

    bfs_clear_timer #(.CLEAR_CYC(CLEAR_CYC), .NPH(NUM_PHASE)) clr_i (
        .clk(clk), .rst_n(rst_n), .latched_i(oc_latched), .lo_s_i(lo_s),
        .done_o(clr_done));

    // Overcurrent latch: set by reset or a qualified trip; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n || trip_hit) begin
            oc_latched <= 1'b1;
        end else if (clr_done) begin
            oc_latched <= 1'b0;
        end
    end

    // Combine latched and live conditions into the drive-disable outputs.
    always_comb begin
        gate_kill = oc_latched || uv_logic_s;
        hs_kill   = uv_hs_s | {NUM_PHASE{gate_kill}};
        fault_n   = !gate_kill;
    end

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_latched && !(&lo_s)) |=> oc_latched);
    // R5
    release_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oc_latched) |-> $past(&lo_s));
    // R2
    set_needs_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_latched) |-> $past(trip_s));
endmodule

// File: tb/bridge_fault_supervisor_tb.sv
// Directed bench: one task per scenario, each checking its own outputs.
// Inputs change on the falling edge; outputs are sampled on the falling edge.
module bridge_fault_supervisor_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  BLANK      = 8;
    localparam int  CLR        = 180;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       trip_in;
    logic       uv_logic_in;
    logic [2:0] uv_hs_in;
    logic [2:0] lo_cmd_n;
    logic       gate_kill;
    logic [2:0] hs_kill;
    logic       fault_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bridge_fault_supervisor #(.BLANK_CYC(BLANK), .CLEAR_CYC(CLR)) dut_i (
        .clk(clk), .rst_n(rst_n), .trip_in(trip_in), .uv_logic_in(uv_logic_in),
        .uv_hs_in(uv_hs_in), .lo_cmd_n(lo_cmd_n), .gate_kill(gate_kill),
        .hs_kill(hs_kill), .fault_n(fault_n));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare {gate_kill, hs_kill, fault_n} against the expectation.
    task automatic chk(input logic [4:0] exp, input string tag);
        logic [4:0] act;
        act = {gate_kill, hs_kill, fault_n};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: {kill,hs,fault_n} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    localparam logic [4:0] ALL_OFF = 5'b1_111_0;
    localparam logic [4:0] RUNNING = 5'b0_000_1;

    task automatic t_reset();
        rst_n = 1'b0; trip_in = 0; uv_logic_in = 0; uv_hs_in = 0; lo_cmd_n = 3'b111;
        step(4);
        rst_n = 1'b1;
        step(3);
        chk(ALL_OFF, "R1 latched after reset");
        step(CLR - 2);
        chk(ALL_OFF, "R1 still latched one edge before clear");
        step(1);
        chk(RUNNING, "R5 cleared after reset sequence");
    endtask

    task automatic t_trip_long();
        lo_cmd_n = 3'b110;
        step(3);
        trip_in = 1'b1;
        step(BLANK + 1);
        chk(RUNNING, "R2 no shutdown one edge early");
        step(1);
        chk(ALL_OFF, "R2 shutdown at blank+2");
        trip_in = 1'b0;
        step(20);
        chk(ALL_OFF, "R4 latch holds after trip removed");
        lo_cmd_n = 3'b111;
        step(CLR + 1);
        chk(ALL_OFF, "R5 not released one edge early");
        step(1);
        chk(RUNNING, "R5 released at clear+2");
    endtask

    task automatic t_trip_short();
        lo_cmd_n = 3'b111;
        trip_in = 1'b1;
        step(BLANK - 1);
        trip_in = 1'b0;
        step(BLANK + 4);
        chk(RUNNING, "R3 short pulse ignored");
        trip_in = 1'b1;
        step(BLANK - 1);
        trip_in = 1'b0;
        step(1);
        trip_in = 1'b1;
        step(BLANK - 1);
        trip_in = 1'b0;
        step(BLANK + 4);
        chk(RUNNING, "R3 gap restarts blanking");
    endtask

    task automatic t_clear_restart();
        lo_cmd_n = 3'b110;
        trip_in = 1'b1;
        step(BLANK + 4);
        trip_in = 1'b0;
        chk(ALL_OFF, "R2 trip latched for restart test");
        lo_cmd_n = 3'b111;
        step(CLR / 2);
        lo_cmd_n = 3'b011;
        step(1);
        lo_cmd_n = 3'b111;
        step(CLR + 1);
        chk(ALL_OFF, "R6 interval restarted by low command");
        step(1);
        chk(RUNNING, "R6 release after full restarted interval");
    endtask

    task automatic t_uv_logic();
        lo_cmd_n = 3'b111;
        uv_logic_in = 1'b1;
        step(1);
        chk(RUNNING, "R7 no response after one edge");
        step(1);
        chk(ALL_OFF, "R7 logic undervoltage kills all");
        step(CLR + 10);
        uv_logic_in = 1'b0;
        step(1);
        chk(ALL_OFF, "R7 release not before two edges");
        step(1);
        chk(RUNNING, "R7 undervoltage not latched");
    endtask

    task automatic t_uv_hs();
        for (int i = 0; i < 3; i++) begin
            logic [2:0] one;
            one = 3'b001 << i;
            uv_hs_in = one;
            step(2);
            chk({1'b0, one, 1'b1}, "R8 high-side undervoltage on one phase only");
            uv_hs_in = 3'b000;
            step(2);
            chk(RUNNING, "R8 high-side undervoltage released");
        end
    endtask

    initial begin
        t_reset();
        t_trip_long();
        t_trip_short();
        t_clear_restart();
        t_uv_logic();
        t_uv_hs();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule